// File: doc/BRIEF.md
# UART Break Generator

This block decides when a UART transmitter must stop sending characters and hold its output line in the break (continuous low) condition, and when the line is handed back. A start-break pulse is accepted only from the idle state. The block then waits until both the holding register and the transmit shift register report empty. Only after that does it override the line low. The low level lasts at least one full character time, measured in bit-period ticks. A stop-break pulse ends the low period. The line is then driven high for a fixed recovery gap of 12 bit periods before the override is released.

The transmitter uses two outputs. `lineForce` selects the override. `lineLevel` gives the level to drive while the override is active. The `busy` flag tells the transmitter to hold back new characters, from the moment a start command is accepted until the recovery gap has finished. A synchronous transmitter reset drops any break in progress. Character framing and serialization are not part of this block.

Top module: `uart_break_gen`

## Requirements
- R1: A start-break pulse in the idle state sets `busy` on the next clock edge. `lineForce` rises with `lineLevel`=0 (line low) only on the edge after a cycle in which `holdEmpty` and `shiftEmpty` are both 1. While either flag is 0 the line is not overridden (`lineForce`=0).
- R2: A start-break pulse while `busy` is 1 has no effect on the outputs or on the progress of the break.
- R3: The low period covers exactly CHAR_BITS `bitTick` pulses, counted from the edge on which the low period began, where CHAR_BITS = 1 + DATA_BITS + PARITY_BITS + STOP_BITS. A stop-break pulse that arrives during those ticks, or together with the last one, is remembered. In that case the recovery gap starts right after the last tick. If no stop has arrived, the line stays low until the next stop-break pulse, and the recovery gap begins on the edge after that pulse.
- R4: A stop-break pulse that arrives while the block is still waiting for the registers to drain is dropped. It is not remembered for the later low period.
- R5: A stop-break pulse while the block is idle has no effect; all outputs stay 0.
- R6: During the recovery gap `lineForce`=1 and `lineLevel`=1. The gap lasts exactly RECOV_BITS (default 12) `bitTick` pulses. On the edge after the last of them, `busy`, `lineForce` and `lineLevel` all return to 0.
- R7: `busy` stays 1 without a break from the accepted start-break pulse until the end of the recovery gap.
- R8: `txReset`=1 on a clock edge returns the block to idle: all three outputs are 0 after that edge, and any remembered stop-break pulse is discarded.
- R9: An active-low `rstN` clears all outputs at once, asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txReset | input | 1 | Synchronous transmitter reset |
| startBreak | input | 1 | Start-break command pulse |
| stopBreak | input | 1 | Stop-break command pulse |
| holdEmpty | input | 1 | Transmit holding register is empty |
| shiftEmpty | input | 1 | Transmit shift register is empty |
| bitTick | input | 1 | One pulse per bit period |
| busy | output | 1 | Break sequence in progress; transmitter must hold off |
| lineForce | output | 1 | 1 = TXD overridden by `lineLevel` |
| lineLevel | output | 1 | Level driven on TXD while overridden |

## Verification
The hardest case to reach from the ports is a stop-break pulse that falls inside the minimum low period. It must be stored and then acted on several ticks later, while a stop pulse sent during the drain wait must be dropped. The stimulus table sends a stop pulse during the drain wait and checks that the low period then stalls in the minimum-reached state. It sends another stop pulse on the first tick of a later break and checks that recovery begins exactly on the seventh tick. A third break stores a stop, is interrupted by a transmitter reset, and is restarted, to show that the stored stop does not carry into the new break.

// File: rtl/uart_break_pkg.sv
package uart_break_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_LOW     = 3'd2,
    ST_LOW_MIN = 3'd3,
    ST_RECOVER = 3'd4
  } brk_state_e;

  typedef struct packed {
    logic cntClear;
    logic selRecover;
    logic stopSet;
    logic stopClear;
  } brk_strobe_t;

endpackage

// File: rtl/uart_break_datapath.sv
module uart_break_datapath
  import uart_break_pkg::*;
#(
  parameter int CHAR_BITS  = 11,
  parameter int RECOV_BITS = 12,
  parameter int CNT_W      = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTick,
  input  brk_strobe_t strobe,
  output logic        limitHit,
  output logic        stopPending
);

  localparam logic [CNT_W-1:0] CHAR_LAST  = CNT_W'(CHAR_BITS - 1);
  localparam logic [CNT_W-1:0] RECOV_LAST = CNT_W'(RECOV_BITS - 1);

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] lastValue;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               tickCnt <= '0;
    else if (strobe.cntClear) tickCnt <= '0;
    else if (bitTick)        tickCnt <= tickCnt + 1'b1;
  end

  assign lastValue = strobe.selRecover ? RECOV_LAST : CHAR_LAST;
  assign limitHit  = bitTick && (tickCnt == lastValue);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 stopPending <= 1'b0;
    else if (strobe.stopClear) stopPending <= 1'b0;
    else if (strobe.stopSet)   stopPending <= 1'b1;
  end

  // R3: a remembered stop can only come from a stop command seen in the low period
  assert_pending_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopPending) |-> $past(strobe.stopSet));

endmodule

// File: rtl/uart_break_ctrl.sv
module uart_break_ctrl
  import uart_break_pkg::*;
#(
  parameter int CHAR_BITS  = 11,
  parameter int RECOV_BITS = 12,
  parameter int CNT_W      = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        txReset,
  input  logic        startBreak,
  input  logic        stopBreak,
  input  logic        holdEmpty,
  input  logic        shiftEmpty,
  input  logic        bitTick,
  input  logic        limitHit,
  input  logic        stopPending,
  output brk_strobe_t strobe,
  output logic        busy,
  output logic        lineForce,
  output logic        lineLevel
);

  brk_state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    if (txReset) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:    if (startBreak) nextState = ST_DRAIN;
        ST_DRAIN:   if (holdEmpty && shiftEmpty) nextState = ST_LOW;
        ST_LOW:     if (limitHit) nextState = (stopPending || stopBreak) ? ST_RECOVER : ST_LOW_MIN;
        ST_LOW_MIN: if (stopBreak) nextState = ST_RECOVER;
        ST_RECOVER: if (limitHit) nextState = ST_IDLE;
        default:    nextState = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.cntClear   = (nextState != state) || (state == ST_IDLE) || (state == ST_DRAIN);
    strobe.selRecover = (state == ST_RECOVER);
    strobe.stopSet    = (state == ST_LOW) && stopBreak;
    strobe.stopClear  = txReset || (state != ST_LOW);
  end

  assign busy      = (state != ST_IDLE);
  assign lineForce = (state == ST_LOW) || (state == ST_LOW_MIN) || (state == ST_RECOVER);
  assign lineLevel = (state == ST_RECOVER);

  // Independent tick tallies kept for the checks below
  localparam int AW = CNT_W + 1;
  localparam logic [AW-1:0] CHAR_CMP  = AW'(CHAR_BITS);
  localparam logic [AW-1:0] RECOV_CMP = AW'(RECOV_BITS);
  logic [AW-1:0] lowTicks, recTicks;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowTicks <= '0;
      recTicks <= '0;
    end else if (state == ST_DRAIN) begin
      lowTicks <= '0;
      recTicks <= '0;
    end else begin
      if (state == ST_LOW && bitTick)     lowTicks <= lowTicks + 1'b1;
      if (state == ST_RECOVER && bitTick) recTicks <= recTicks + 1'b1;
    end
  end

  assert_low_needs_empty_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineForce) |-> $past(holdEmpty && shiftEmpty) && !lineLevel);

  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lineForce && startBreak && !txReset) |=> (state != ST_DRAIN) && busy);

  assert_min_low_length_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineLevel) |-> (lowTicks == CHAR_CMP));

  assert_idle_stop_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopBreak && !startBreak) |=> !busy && !lineForce);

  assert_recovery_length_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !$past(txReset)) |-> (recTicks == RECOV_CMP));

  assert_tx_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    txReset |=> !busy && !lineForce && !lineLevel);

endmodule

// File: rtl/uart_break_gen.sv
module uart_break_gen
  import uart_break_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int PARITY_BITS = 1,
  parameter int STOP_BITS   = 1,
  parameter int RECOV_BITS  = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic txReset,
  input  logic startBreak,
  input  logic stopBreak,
  input  logic holdEmpty,
  input  logic shiftEmpty,
  input  logic bitTick,
  output logic busy,
  output logic lineForce,
  output logic lineLevel
);

  localparam int CHAR_BITS = 1 + DATA_BITS + PARITY_BITS + STOP_BITS;
  localparam int MAX_SPAN  = (CHAR_BITS > RECOV_BITS) ? CHAR_BITS : RECOV_BITS;
  localparam int CNT_W     = $clog2(MAX_SPAN + 1);

  brk_strobe_t strobe;
  logic        limitHit;
  logic        stopPending;

  uart_break_ctrl #(
    .CHAR_BITS (CHAR_BITS),
    .RECOV_BITS(RECOV_BITS),
    .CNT_W     (CNT_W)
  ) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txReset    (txReset),
    .startBreak (startBreak),
    .stopBreak  (stopBreak),
    .holdEmpty  (holdEmpty),
    .shiftEmpty (shiftEmpty),
    .bitTick    (bitTick),
    .limitHit   (limitHit),
    .stopPending(stopPending),
    .strobe     (strobe),
    .busy       (busy),
    .lineForce  (lineForce),
    .lineLevel  (lineLevel)
  );

  uart_break_datapath #(
    .CHAR_BITS (CHAR_BITS),
    .RECOV_BITS(RECOV_BITS),
    .CNT_W     (CNT_W)
  ) dp (
    .clk        (clk),
    .rstN       (rstN),
    .bitTick    (bitTick),
    .strobe     (strobe),
    .limitHit   (limitHit),
    .stopPending(stopPending)
  );

endmodule

// File: tb/uart_break_gen_test.sv
module uart_break_gen_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txReset = 1'b0, startBreak = 1'b0, stopBreak = 1'b0;
  logic holdEmpty = 1'b0, shiftEmpty = 1'b0, bitTick = 1'b0;
  logic busy, lineForce, lineLevel;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // 5 data bits, no parity, 1 stop bit -> 7 ticks per character
  uart_break_gen #(.DATA_BITS(5), .PARITY_BITS(0), .STOP_BITS(1), .RECOV_BITS(12)) uut (
    .clk(clk), .rstN(rstN), .txReset(txReset), .startBreak(startBreak),
    .stopBreak(stopBreak), .holdEmpty(holdEmpty), .shiftEmpty(shiftEmpty),
    .bitTick(bitTick), .busy(busy), .lineForce(lineForce), .lineLevel(lineLevel)
  );

  // {txReset,start,stop,holdEmpty,shiftEmpty,tick}, repeats, {busy,force,level}, requirement
  localparam int NV = 32;
  localparam logic [17:0] VEC [NV] = '{
    {6'b010011, 5'd1,  3'b100, 4'd1},
    {6'b000011, 5'd1,  3'b100, 4'd1},
    {6'b000101, 5'd1,  3'b100, 4'd1},
    {6'b001011, 5'd1,  3'b100, 4'd4},
    {6'b010110, 5'd1,  3'b110, 4'd1},
    {6'b000111, 5'd6,  3'b110, 4'd3},
    {6'b010110, 5'd2,  3'b110, 4'd2},
    {6'b000111, 5'd1,  3'b110, 4'd4},
    {6'b010111, 5'd3,  3'b110, 4'd2},
    {6'b001110, 5'd1,  3'b111, 4'd3},
    {6'b000111, 5'd11, 3'b111, 4'd6},
    {6'b000110, 5'd2,  3'b111, 4'd6},
    {6'b000111, 5'd1,  3'b000, 4'd6},
    {6'b001111, 5'd2,  3'b000, 4'd5},
    {6'b010111, 5'd1,  3'b100, 4'd7},
    {6'b000111, 5'd1,  3'b110, 4'd1},
    {6'b001111, 5'd1,  3'b110, 4'd3},
    {6'b000111, 5'd5,  3'b110, 4'd3},
    {6'b000111, 5'd1,  3'b111, 4'd3},
    {6'b000111, 5'd5,  3'b111, 4'd7},
    {6'b100111, 5'd1,  3'b000, 4'd8},
    {6'b001111, 5'd1,  3'b000, 4'd8},
    {6'b010111, 5'd1,  3'b100, 4'd7},
    {6'b000111, 5'd1,  3'b110, 4'd1},
    {6'b001111, 5'd1,  3'b110, 4'd3},
    {6'b100111, 5'd1,  3'b000, 4'd8},
    {6'b010111, 5'd1,  3'b100, 4'd8},
    {6'b000111, 5'd1,  3'b110, 4'd8},
    {6'b000111, 5'd6,  3'b110, 4'd8},
    {6'b000111, 5'd1,  3'b110, 4'd8},
    {6'b001111, 5'd1,  3'b111, 4'd3},
    {6'b100111, 5'd1,  3'b000, 4'd8}
  };

  function automatic string reqName(input int r);
    case (r)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic checkOut(input logic [2:0] exp, input string req);
    checks++;
    if ({busy, lineForce, lineLevel} !== exp) begin
      errors++;
      $display("FAIL %s: busy/force/level got %b expected %b at %0t",
               req, {busy, lineForce, lineLevel}, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, got hang expected completion");
    finishRun();
  end

  initial begin
    #12;
    checkOut(3'b000, "R9");            // R9 reset state
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOut(3'b000, "R9");

    for (int v = 0; v < NV; v++) begin
      for (int n = 0; n < int'(VEC[v][11:7]); n++) begin
        {txReset, startBreak, stopBreak, holdEmpty, shiftEmpty, bitTick} = VEC[v][17:12];
        @(posedge clk);
        #2;
        checkOut(VEC[v][6:4], reqName(int'(VEC[v][3:0])));
        @(negedge clk);
      end
    end

    // R9: asynchronous reset in the middle of the recovery gap
    {txReset, startBreak, stopBreak, holdEmpty, shiftEmpty, bitTick} = 6'b010111;
    @(negedge clk);
    {txReset, startBreak, stopBreak, holdEmpty, shiftEmpty, bitTick} = 6'b000111;
    for (int k = 0; k < 8; k++) @(negedge clk);
    stopBreak = 1'b1;
    @(negedge clk);
    stopBreak = 1'b0;
    @(negedge clk);
    checkOut(3'b111, "R6");
    #1;
    rstN = 1'b0;
    #1;
    checkOut(3'b000, "R9");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOut(3'b000, "R9");

    finishRun();
  end

endmodule